// File: doc/BRIEF.md
# Balanced 4b/6b Byte Codec

This block carries bytes across a serial link as a DC-balanced bit stream. The transmit half accepts a byte on a valid/ready handshake. It replaces each nibble with a 6-bit code word that holds three ones and three zeros, and then shifts the 12 resulting bits out one at a time. It advances by one bit on each cycle in which the bit-enable strobe is high. The receive half shifts in one bit on each cycle in which its own strobe is high. After twelve bits it turns the two 6-bit groups back into a byte and flags any group that is not a legal code word.

The line rate is set by the strobes, which are driven from outside. Framing, such as a start pattern that aligns the receiver, is handled elsewhere. The receive half offers a synchronous clear for that purpose, which restarts its bit count. The code set contains only balanced words, so the line keeps no DC offset. The code set also never produces the 16-bit pattern E2E2 hex, so a framing layer can use that pattern as a marker.

Top module: `bal46_codec`

## Requirements
- R1: Nibble values 0 through F are sent as the 6-bit code words 0D, 0E, 13, 15, 16, 19, 1A, 1C, 23, 25, 26, 29, 2A, 2C, 32, 34 (hex), in that order.
- R2: Each accepted byte produces 12 line bits. The code of bits 7:4 goes first, and each code goes most significant bit first. A bit counts as sent when `tx_bit_en` is high in the cycle where it is presented on `tx_bit`.
- R3: `tx_ready` is high when no line bits are pending, or when exactly one is pending and `tx_bit_en` is high in that cycle. A byte is accepted in a cycle where `tx_valid` and `tx_ready` are both high. This lets bytes follow each other with no idle bit between them.
- R4: While no line bits are pending, `tx_bit` is 0 and a high `tx_bit_en` has no effect.
- R5: Every code word holds exactly three ones, so the running disparity of the line is zero at every byte boundary.
- R6: No sequence of accepted bytes produces the 16-bit pattern E2E2 hex anywhere in the line stream.
- R7: In the cycle after the twelfth strobed receive bit, `rx_byte_valid` is high for exactly one cycle. At the same time `rx_byte` holds the decoded byte, and the first bit received becomes the most significant bit of the high group.
- R8: A received 6-bit group that is not in the R1 table decodes to nibble 0 and sets `rx_err` for that byte. Legal groups in the same byte decode normally.
- R9: `rx_clear` discards any partial receive byte and restarts the bit count at zero. It takes priority over a receive strobe in the same cycle, which is then ignored. No `rx_byte_valid` follows a clear cycle.
- R10: After reset, `tx_ready` = 1, `tx_bit` = 0, `rx_byte_valid` = 0, `rx_err` = 0 and `rx_byte` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_byte | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_byte` is offered |
| tx_ready | output | 1 | A byte can be accepted this cycle |
| tx_bit_en | input | 1 | Advance the line by one bit |
| tx_bit | output | 1 | Current line bit |
| rx_bit | input | 1 | Received line bit |
| rx_bit_en | input | 1 | Take `rx_bit` this cycle |
| rx_clear | input | 1 | Restart receive bit alignment |
| rx_byte | output | 8 | Decoded byte |
| rx_byte_valid | output | 1 | One-cycle strobe: `rx_byte` is new |
| rx_err | output | 1 | Illegal group in the byte on `rx_byte` |

## Verification
The assertions assume the following about the inputs. `tx_byte` is only sampled in a cycle where the handshake completes. `rx_clear` and the receive strobe arrive on clock edges with reset released. The receive strobe carries bits from a source that is aligned to 12-bit boundaries, apart from the misaligned bits that come before a clear. The stimulus meets these conditions. It holds `tx_valid` and the offered byte until acceptance, and it feeds the receiver either the transmitted line bits in loopback or whole hand-built 12-bit groups. The only partial group it sends is the one that is deliberately followed by `rx_clear`.

// File: rtl/bal46_pkg.sv
package bal46_pkg;

  localparam int NIB_W = 4;
  localparam int SYM_W = 6;

  typedef struct packed {
    logic       bad;
    logic [3:0] nib;
  } sym_dec_t;

  function automatic logic [SYM_W-1:0] nib_to_sym(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] s;
    case (n)
      4'h0: s = 6'h0D;
      4'h1: s = 6'h0E;
      4'h2: s = 6'h13;
      4'h3: s = 6'h15;
      4'h4: s = 6'h16;
      4'h5: s = 6'h19;
      4'h6: s = 6'h1A;
      4'h7: s = 6'h1C;
      4'h8: s = 6'h23;
      4'h9: s = 6'h25;
      4'hA: s = 6'h26;
      4'hB: s = 6'h29;
      4'hC: s = 6'h2A;
      4'hD: s = 6'h2C;
      4'hE: s = 6'h32;
      default: s = 6'h34;
    endcase
    return s;
  endfunction

  // Reverse lookup; an unknown group yields nibble 0 with bad set.
  function automatic sym_dec_t sym_to_nib(input logic [SYM_W-1:0] s);
    sym_dec_t d;
    d.bad = 1'b1;
    d.nib = '0;
    for (int k = 0; k < 16; k++) begin
      if (nib_to_sym(4'(k)) == s) begin
        d.bad = 1'b0;
        d.nib = 4'(k);
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/bal46_enc.sv
module bal46_enc
  import bal46_pkg::*;
#(
  parameter int NIBBLES = 2
) (
  input  logic [NIB_W*NIBBLES-1:0] word_i,
  output logic [SYM_W*NIBBLES-1:0] code_o
);
  // Nibble g sits in the same relative slot of the code, so the high
  // nibble's symbol occupies the top bits and leaves the line first.
  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    assign code_o[SYM_W*g +: SYM_W] = nib_to_sym(word_i[NIB_W*g +: NIB_W]);
  end
endmodule

// File: rtl/bal46_tx.sv
module bal46_tx
  import bal46_pkg::*;
#(
  parameter int NIBBLES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NIB_W*NIBBLES-1:0] in_word,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     bit_en,
  output logic                     bit_out
);
  localparam int CODE_W = SYM_W * NIBBLES;
  localparam int CNT_W  = $clog2(CODE_W + 1);

  logic [CODE_W-1:0] shreg;
  logic [CNT_W-1:0]  bits_left;
  logic [CODE_W-1:0] code_w;

  bal46_enc #(.NIBBLES(NIBBLES)) enc_i (
    .word_i (in_word),
    .code_o (code_w)
  );

  // Named events for the assertions.
  logic shift_evt, last_evt, load_evt;
  assign shift_evt = bit_en && (bits_left != '0);
  assign last_evt  = shift_evt && (bits_left == CNT_W'(1));
  assign in_ready  = (bits_left == '0) || last_evt;
  assign load_evt  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      bits_left <= '0;
    end else if (load_evt) begin
      shreg     <= code_w;
      bits_left <= CNT_W'(CODE_W);
    end else if (shift_evt) begin
      shreg     <= {shreg[CODE_W-2:0], 1'b0};
      bits_left <= bits_left - CNT_W'(1);
    end
  end

  assign bit_out = shreg[CODE_W-1];

  assert_load_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> bits_left == CNT_W'(CODE_W));

  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && !load_evt) |=> bits_left == $past(bits_left) - CNT_W'(1));

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_left == '0) |-> !bit_out);

  assert_balanced_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> $countones(shreg) == 3 * NIBBLES);

  assert_idle_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_left == '0 && !in_valid) |=> bits_left == '0);
endmodule

// File: rtl/bal46_rx.sv
module bal46_rx
  import bal46_pkg::*;
#(
  parameter int NIBBLES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_in,
  input  logic                     bit_en,
  input  logic                     clear,
  output logic [NIB_W*NIBBLES-1:0] out_word,
  output logic                     out_valid,
  output logic                     out_err
);
  localparam int CODE_W = SYM_W * NIBBLES;
  localparam int CNT_W  = $clog2(CODE_W);

  logic [CODE_W-1:0] shreg;
  logic [CODE_W-1:0] next_shreg;
  logic [CNT_W-1:0]  bit_cnt;

  logic shift_evt, full_evt;
  assign shift_evt  = bit_en && !clear;
  assign full_evt   = shift_evt && (bit_cnt == CNT_W'(CODE_W - 1));
  assign next_shreg = {shreg[CODE_W-2:0], bit_in};

  logic [NIB_W*NIBBLES-1:0] dec_word;
  logic [NIBBLES-1:0]       dec_bad;

  for (genvar g = 0; g < NIBBLES; g++) begin : g_grp
    sym_dec_t d;
    assign d = sym_to_nib(next_shreg[SYM_W*g +: SYM_W]);
    assign dec_word[NIB_W*g +: NIB_W] = d.nib;
    assign dec_bad[g] = d.bad;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= full_evt;
      if (full_evt) begin
        out_word <= dec_word;
        out_err  <= |dec_bad;
      end
      if (clear) begin
        shreg   <= '0;
        bit_cnt <= '0;
      end else if (shift_evt) begin
        shreg   <= next_shreg;
        bit_cnt <= full_evt ? '0 : bit_cnt + CNT_W'(1);
      end
    end
  end

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_clear_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !out_valid);

  assert_clear_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> bit_cnt == '0);

  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(CODE_W));
endmodule

// File: rtl/bal46_codec.sv
module bal46_codec
  import bal46_pkg::*;
#(
  parameter int NIBBLES = 2,
  localparam int WORD_W = NIB_W * NIBBLES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tx_byte,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              tx_bit_en,
  output logic              tx_bit,
  input  logic              rx_bit,
  input  logic              rx_bit_en,
  input  logic              rx_clear,
  output logic [WORD_W-1:0] rx_byte,
  output logic              rx_byte_valid,
  output logic              rx_err
);
  bal46_tx #(.NIBBLES(NIBBLES)) tx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_word  (tx_byte),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .bit_en   (tx_bit_en),
    .bit_out  (tx_bit)
  );

  bal46_rx #(.NIBBLES(NIBBLES)) rx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_in    (rx_bit),
    .bit_en    (rx_bit_en),
    .clear     (rx_clear),
    .out_word  (rx_byte),
    .out_valid (rx_byte_valid),
    .out_err   (rx_err)
  );
endmodule

// File: tb/bal46_codec_tb_top.sv
`timescale 1ns/1ps
module bal46_codec_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       tx_valid = 1'b0, tx_bit_en = 1'b0;
  logic       rx_bit = 1'b0, rx_bit_en = 1'b0, rx_clear = 1'b0;
  logic       tx_ready, tx_bit, rx_byte_valid, rx_err;
  logic [7:0] rx_byte;

  always #2 clk = ~clk;

  bal46_codec dut_i (
    .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_bit_en(tx_bit_en), .tx_bit(tx_bit),
    .rx_bit(rx_bit), .rx_bit_en(rx_bit_en), .rx_clear(rx_clear),
    .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid), .rx_err(rx_err)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Reference state
  bit        txq[$];
  int        line_bits = 0, disp = 0;
  bit [15:0] win = '0;
  int        rcnt = 0;
  bit [11:0] rsh = '0;
  bit        rx_exp_v = 0, rx_exp_err = 0;
  bit [7:0]  rx_exp_b = '0;
  bit        last_acc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Code k = k-th 6-bit value of weight three, skipping 07, 0B, 31, 38.
  function automatic bit [5:0] ref_code(input int n);
    int idx = 0;
    bit [5:0] r = '0;
    for (int v = 0; v < 64; v++) begin
      if ($countones(v) == 3 && v != 7 && v != 11 && v != 49 && v != 56) begin
        if (idx == n) r = 6'(v);
        idx++;
      end
    end
    return r;
  endfunction

  function automatic int ref_nib(input bit [5:0] s);
    int r = -1;
    for (int k = 0; k < 16; k++) if (ref_code(k) == s) r = k;
    return r;
  endfunction

  task automatic cycle(input bit tv, input bit [7:0] tb, input bit ten,
                       input bit rb, input bit ren, input bit rclr);
    bit rdy;
    @(negedge clk);
    tx_valid = tv; tx_byte = tb; tx_bit_en = ten;
    rx_bit = rb; rx_bit_en = ren; rx_clear = rclr;
    #1;
    chk(rx_byte_valid == rx_exp_v, "R7 R9 rx_byte_valid", rx_byte_valid, rx_exp_v);
    if (rx_exp_v) begin
      chk(rx_byte == rx_exp_b, "R7 R8 rx_byte", rx_byte, rx_exp_b);
      chk(rx_err == rx_exp_err, "R8 rx_err", rx_err, rx_exp_err);
    end
    rdy = (txq.size() == 0) || (txq.size() == 1 && ten);
    chk(tx_ready == rdy, "R3 tx_ready", tx_ready, rdy);
    if (txq.size() == 0) chk(tx_bit == 1'b0, "R4 idle tx_bit", tx_bit, 0);
    else if (ten) begin
      chk(tx_bit == txq[0], "R1 R2 tx_bit", tx_bit, txq[0]);
      void'(txq.pop_front());
      line_bits++;
      win = {win[14:0], tx_bit};
      disp += tx_bit ? 1 : -1;
      if (line_bits >= 16) chk(win != 16'hE2E2, "R6 forbidden pattern", win, 0);
      if (line_bits % 12 == 0) chk(disp == 0, "R5 disparity", disp, 0);
    end
    last_acc = tv && rdy;
    if (last_acc) begin
      bit [11:0] c = {ref_code(int'(tb[7:4])), ref_code(int'(tb[3:0]))};
      for (int i = 11; i >= 0; i--) txq.push_back(c[i]);
    end
    rx_exp_v = 0;
    if (rclr) begin
      rcnt = 0; rsh = '0;
    end else if (ren) begin
      rsh = {rsh[10:0], rb};
      rcnt++;
      if (rcnt == 12) begin
        int h = ref_nib(rsh[11:6]);
        int l = ref_nib(rsh[5:0]);
        rcnt = 0;
        rx_exp_v = 1;
        rx_exp_err = (h < 0) || (l < 0);
        rx_exp_b = {4'(h < 0 ? 0 : h), 4'(l < 0 ? 0 : l)};
      end
    end
  endtask

  task automatic loop_cycle(input bit tv, input bit [7:0] tb, input bit ten);
    bit has = txq.size() > 0;
    cycle(tv, tb, ten, has ? txq[0] : 1'b0, ten && has, 1'b0);
  endtask

  task automatic send_rx(input bit [11:0] g);
    for (int i = 11; i >= 0; i--) cycle(0, 0, 0, g[i], 1, 0);
    cycle(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(tx_ready == 1, "R10 tx_ready", tx_ready, 1);
    chk(tx_bit == 0, "R10 tx_bit", tx_bit, 0);
    chk(rx_byte_valid == 0, "R10 rx_byte_valid", rx_byte_valid, 0);
    chk(rx_err == 0, "R10 rx_err", rx_err, 0);
    chk(rx_byte == 0, "R10 rx_byte", rx_byte, 0);

    // R1 R2 R3: every nibble, back to back at full rate
    for (int b = 0; b < 8; b++) begin
      bit [7:0] v = {4'(2*b), 4'(2*b+1)};
      do loop_cycle(1, v, 1); while (!last_acc);
    end
    while (txq.size() > 0) loop_cycle(0, 0, 1);
    repeat (2) loop_cycle(0, 0, 0);

    // R4: strobes while idle
    repeat (20) loop_cycle(0, 0, 1);

    // Random traffic: R2 R3 R5 R6 R7
    begin
      bit tv = 1; bit [7:0] tb = 8'($urandom);
      for (int c = 0; c < 6000; c++) begin
        loop_cycle(tv, tb, 1'($urandom % 2));
        if (last_acc || !tv) begin
          tv = ($urandom % 3) != 0;
          tb = 8'($urandom);
        end
      end
    end
    while (txq.size() > 0) loop_cycle(0, 0, 1);
    repeat (2) loop_cycle(0, 0, 0);

    // R8: illegal groups
    send_rx({6'h07, 6'h0D});
    send_rx({6'h34, 6'h3F});
    send_rx({6'h00, 6'h00});
    send_rx({6'h1A, 6'h29});

    // R9: partial group, clear together with a strobe, then a full group
    for (int i = 0; i < 5; i++) cycle(0, 0, 0, 1, 1, 0);
    cycle(0, 0, 0, 1, 1, 1);
    send_rx({6'h32, 6'h16});
    for (int i = 0; i < 11; i++) cycle(0, 0, 0, 0, 1, 0);
    cycle(0, 0, 0, 0, 0, 1);
    send_rx({6'h0E, 6'h2C});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule